// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one short command on a single-lane SPI flash bus each time software asks for it. Software writes a command word that packs every phase of the command: the opcode, whether an address follows and how many bytes it has, a number of dummy clocks, and optional write and read data phases of up to eight bytes each. It also writes the address and outgoing data into holding registers. Setting the execute bit in the command word starts the transfer. The block lowers chip select and shifts the phases out in a fixed order. Bytes received in the read phase land in two 32-bit read holding registers.

The serial clock is made from a shift-enable strobe supplied from outside. Each strobe moves the serial clock by half a period, so the bit rate is set wholly by how often the strobe arrives. A busy output, an in-progress bit in the command word and an idle bit in a status register all show whether a command is running. Software waits for three idle reads in a row before it treats the block as idle.

Register map by `regAddr`: 0 command word, 1 flash address, 2 write data low, 3 write data high, 4 read data low (read-only), 5 read data high (read-only), 6 status (read-only). Any other index reads as zero.

Top module: `flash_cmd_seq`

## Requirements
- R1: The command word has these fields: opcode in bits 31:24, read enable in bit 23, read count in bits 22:20, address enable in bit 19, address count in bits 17:16, write enable in bit 15, write count in bits 14:12 and dummy clock count in bits 11:7. Every byte-count field holds the count minus one. Bits 31:2 read back as they were written.
- R2: Writing 1 to bit 0 of the command word starts a command. Bit 0 always reads 0. Bit 1 reads 1 from the execute write until chip select rises at the end of the command.
- R3: Phases run in this order: opcode, address (if enabled), dummy clocks (if the count is not zero), write data (if enabled), read data (if enabled). A disabled phase takes no clocks. Chip select falls once and stays low until the last bit ends.
- R4: The serial clock idles low. MOSI changes only on the falling edge of the serial clock and stays stable while the clock is high. MISO is sampled on the rising edge. Every byte goes out most significant bit first.
- R5: The address phase sends the lowest (address count + 1) bytes of the address register, starting with the most significant of those bytes.
- R6: Write byte k comes from bits 8k+7:8k of {write-high, write-low}. Byte 0 is write-low bits 7:0, and bytes 4 to 7 come from write-high.
- R7: Read byte k goes into bits 8k+7:8k of {read-high, read-low}, so byte 0 is read-low bits 7:0. Each execute clears both read registers, so bytes past the count read as zero.
- R8: A dummy count of N adds exactly N serial clock periods with MOSI low. A count of 0 adds none.
- R9: While a command is in progress, any write to the command word is ignored. It does not start a new command and does not change the stored fields.
- R10: Status bit 0 reads 1 only when no command is pending or running. All other status bits read 0.
- R11: The serial clock changes level only in the cycle after a shift-enable strobe. With no strobes, a started command sits with chip select low and the clock low.
- R12: After reset, chip select is high, the clock is low, busy is low, registers 0 to 5 read zero and status reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| shiftEn | input | 1 | Half-period strobe for the serial clock |
| spiClk | output | 1 | Serial clock |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |
| busy | output | 1 | A command is pending or in progress |

## Verification
Two things can happen in the same cycle: a software write to the command word, and the sequencer still holding a command it has not finished. The bench starts a long command with dummy and data phases, then writes a new opcode with execute set partway through. It judges the result three ways: the command word read back after completion, a count of chip-select falls that must be exactly one, and the bus staying idle afterwards. A second overlap comes inside the sequencer itself. On the final falling strobe of a read, the last received byte is stored in the same cycle that chip select rises. The bench checks this through the upper read register for full-length reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int REG_W          = 32;
  localparam int REG_SEL_W      = 3;
  localparam int BYTE_BITS      = 8;
  localparam int MAX_DATA_BYTES = 8;
  localparam int DATA_HOLD_W    = BYTE_BITS * MAX_DATA_BYTES;
  localparam int CNT_W          = $clog2(MAX_DATA_BYTES);
  localparam int BIT_CNT_W      = $clog2(BYTE_BITS);
  localparam int ADDR_CNT_W     = 2;
  localparam int DUMMY_W        = 5;

  localparam logic [REG_SEL_W-1:0] SEL_CTRL = 3'd0;
  localparam logic [REG_SEL_W-1:0] SEL_ADDR = 3'd1;
  localparam logic [REG_SEL_W-1:0] SEL_WLO  = 3'd2;
  localparam logic [REG_SEL_W-1:0] SEL_WHI  = 3'd3;
  localparam logic [REG_SEL_W-1:0] SEL_RLO  = 3'd4;
  localparam logic [REG_SEL_W-1:0] SEL_RHI  = 3'd5;
  localparam logic [REG_SEL_W-1:0] SEL_STAT = 3'd6;

  localparam int POS_OPC     = 24;
  localparam int POS_RDEN    = 23;
  localparam int POS_RDCNT   = 20;
  localparam int POS_ADDREN  = 19;
  localparam int POS_ADDRCNT = 16;
  localparam int POS_WREN    = 15;
  localparam int POS_WRCNT   = 12;
  localparam int POS_DUMMY   = 7;
  localparam int POS_EXEC    = 0;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_WDATA = 3'd4,
    PH_RDATA = 3'd5
  } phase_t;

  typedef enum logic [1:0] {
    SRC_OPC, SRC_ADDR, SRC_WDATA, SRC_ZERO
  } tx_src_t;

  typedef struct packed {
    logic                  rdEn;
    logic [CNT_W-1:0]      rdCnt;
    logic                  addrEn;
    logic [ADDR_CNT_W-1:0] addrCnt;
    logic                  wrEn;
    logic [CNT_W-1:0]      wrCnt;
    logic [DUMMY_W-1:0]    dummy;
  } cmd_fields_t;

  typedef struct packed {
    logic             loadTx;
    tx_src_t          txSrc;
    logic [CNT_W-1:0] byteIdx;
    logic             shiftTx;
    logic             sampleRx;
    logic             storeRx;
    logic             clearRx;
  } seq_strobe_t;
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        shiftEn,
  input  cmd_fields_t cmd,
  output seq_strobe_t strb,
  output logic        active,
  output logic        sclk,
  output logic        csN
);
  phase_t                 phase, nextPh;
  logic [BIT_CNT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]       byteCnt;
  logic [DUMMY_W-1:0]     dumCnt;
  logic                   sclkHi;
  logic                   idle, riseEdge, fallEdge, slotEnd, lastInPhase;
  logic [CNT_W-1:0]       addrTop;

  assign idle     = (phase == PH_IDLE);
  assign riseEdge = !idle && shiftEn && !sclkHi;
  assign fallEdge = !idle && shiftEn && sclkHi;
  assign slotEnd  = fallEdge && ((phase == PH_DUMMY) || (bitCnt == '0));
  assign addrTop  = CNT_W'(cmd.addrCnt);

  function automatic tx_src_t srcOf(phase_t p);
    case (p)
      PH_OPC:   return SRC_OPC;
      PH_ADDR:  return SRC_ADDR;
      PH_WDATA: return SRC_WDATA;
      default:  return SRC_ZERO;
    endcase
  endfunction

  // First enabled phase after the current one, in fixed order
  always_comb begin
    nextPh = PH_IDLE;
    if (phase < PH_RDATA && cmd.rdEn)          nextPh = PH_RDATA;
    if (phase < PH_WDATA && cmd.wrEn)          nextPh = PH_WDATA;
    if (phase < PH_DUMMY && cmd.dummy != '0)   nextPh = PH_DUMMY;
    if (phase < PH_ADDR  && cmd.addrEn)        nextPh = PH_ADDR;
  end

  always_comb begin
    case (phase)
      PH_ADDR:  lastInPhase = (byteCnt == addrTop);
      PH_DUMMY: lastInPhase = (dumCnt == '0);
      PH_WDATA: lastInPhase = (byteCnt == cmd.wrCnt);
      PH_RDATA: lastInPhase = (byteCnt == cmd.rdCnt);
      default:  lastInPhase = 1'b1;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.txSrc    = SRC_ZERO;
    strb.byteIdx  = byteCnt;
    strb.sampleRx = riseEdge;
    strb.shiftTx  = fallEdge && !slotEnd;
    strb.storeRx  = slotEnd && (phase == PH_RDATA);
    if (idle && start) begin
      strb.loadTx  = 1'b1;
      strb.txSrc   = SRC_OPC;
      strb.clearRx = 1'b1;
    end else if (slotEnd && !lastInPhase && phase != PH_DUMMY) begin
      strb.loadTx = 1'b1;
      strb.txSrc  = srcOf(phase);
      if (phase == PH_ADDR)
        strb.byteIdx = addrTop - byteCnt - CNT_W'(1);
      else if (phase == PH_WDATA)
        strb.byteIdx = byteCnt + CNT_W'(1);
    end else if (slotEnd && lastInPhase && nextPh != PH_IDLE) begin
      strb.loadTx  = 1'b1;
      strb.txSrc   = srcOf(nextPh);
      strb.byteIdx = (nextPh == PH_ADDR) ? addrTop : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      dumCnt  <= '0;
      sclkHi  <= 1'b0;
    end else if (idle) begin
      if (start) begin
        phase   <= PH_OPC;
        bitCnt  <= BIT_CNT_W'(BYTE_BITS - 1);
        byteCnt <= '0;
        sclkHi  <= 1'b0;
      end
    end else if (riseEdge) begin
      sclkHi <= 1'b1;
    end else if (fallEdge) begin
      sclkHi <= 1'b0;
      if (!slotEnd) begin
        bitCnt <= bitCnt - BIT_CNT_W'(1);
      end else begin
        bitCnt <= BIT_CNT_W'(BYTE_BITS - 1);
        if (!lastInPhase) begin
          if (phase == PH_DUMMY) dumCnt  <= dumCnt - DUMMY_W'(1);
          else                   byteCnt <= byteCnt + CNT_W'(1);
        end else begin
          phase   <= nextPh;
          byteCnt <= '0;
          dumCnt  <= cmd.dummy - DUMMY_W'(1);
        end
      end
    end
  end

  assign active = !idle;
  assign sclk   = sclkHi;
  assign csN    = idle;
endmodule

// File: rtl/flash_seq_dpath.sv
module flash_seq_dpath
  import flash_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  seq_strobe_t          strb,
  input  logic                 seqActive,
  input  logic                 spiMiso,
  output cmd_fields_t          cmd,
  output logic                 startReq,
  output logic                 busyAll,
  output logic                 mosi
);
  logic [REG_W-1:2]         ctrlHi;
  logic [REG_W-1:0]         cmdAddr, wrLo, wrHi;
  logic [DATA_HOLD_W-1:0]   rdHold;
  logic [DATA_HOLD_W-1:0]   wrHold;
  logic [BYTE_BITS-1:0]     txShift, rxShift, txNext;
  logic                     startPend;
  logic                     ctrlWrite;

  assign busyAll   = seqActive | startPend;
  assign startReq  = startPend;
  assign ctrlWrite = regWrEn && (regAddr == SEL_CTRL) && !busyAll;
  assign wrHold    = {wrHi, wrLo};

  assign cmd.rdEn    = ctrlHi[POS_RDEN];
  assign cmd.rdCnt   = ctrlHi[POS_RDCNT +: CNT_W];
  assign cmd.addrEn  = ctrlHi[POS_ADDREN];
  assign cmd.addrCnt = ctrlHi[POS_ADDRCNT +: ADDR_CNT_W];
  assign cmd.wrEn    = ctrlHi[POS_WREN];
  assign cmd.wrCnt   = ctrlHi[POS_WRCNT +: CNT_W];
  assign cmd.dummy   = ctrlHi[POS_DUMMY +: DUMMY_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlHi    <= '0;
      cmdAddr   <= '0;
      wrLo      <= '0;
      wrHi      <= '0;
      startPend <= 1'b0;
    end else begin
      startPend <= ctrlWrite && regWrData[POS_EXEC];
      if (ctrlWrite) ctrlHi <= regWrData[REG_W-1:2];
      if (regWrEn && regAddr == SEL_ADDR) cmdAddr <= regWrData;
      if (regWrEn && regAddr == SEL_WLO)  wrLo    <= regWrData;
      if (regWrEn && regAddr == SEL_WHI)  wrHi    <= regWrData;
    end
  end

  always_comb begin
    case (strb.txSrc)
      SRC_OPC:   txNext = ctrlHi[POS_OPC +: BYTE_BITS];
      SRC_ADDR:  txNext = cmdAddr[{strb.byteIdx[ADDR_CNT_W-1:0], 3'b000} +: BYTE_BITS];
      SRC_WDATA: txNext = wrHold[{strb.byteIdx, 3'b000} +: BYTE_BITS];
      default:   txNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdHold  <= '0;
    end else begin
      if (strb.loadTx)       txShift <= txNext;
      else if (strb.shiftTx) txShift <= {txShift[BYTE_BITS-2:0], 1'b0};
      if (strb.sampleRx)     rxShift <= {rxShift[BYTE_BITS-2:0], spiMiso};
      if (strb.clearRx)      rdHold  <= '0;
      else if (strb.storeRx) rdHold[{strb.byteIdx, 3'b000} +: BYTE_BITS] <= rxShift;
    end
  end

  assign mosi = txShift[BYTE_BITS-1];

  always_comb begin
    case (regAddr)
      SEL_CTRL: regRdData = {ctrlHi, busyAll, 1'b0};
      SEL_ADDR: regRdData = cmdAddr;
      SEL_WLO:  regRdData = wrLo;
      SEL_WHI:  regRdData = wrHi;
      SEL_RLO:  regRdData = rdHold[REG_W-1:0];
      SEL_RHI:  regRdData = rdHold[DATA_HOLD_W-1:REG_W];
      SEL_STAT: regRdData = {{(REG_W-1){1'b0}}, !busyAll};
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 shiftEn,
  output logic                 spiClk,
  output logic                 spiCsN,
  output logic                 spiMosi,
  input  logic                 spiMiso,
  output logic                 busy
);
  cmd_fields_t cmdFields;
  seq_strobe_t seqStrb;
  logic        startReq;
  logic        seqActive;

  flash_seq_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strb      (seqStrb),
    .seqActive (seqActive),
    .spiMiso   (spiMiso),
    .cmd       (cmdFields),
    .startReq  (startReq),
    .busyAll   (busy),
    .mosi      (spiMosi)
  );

  flash_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (startReq),
    .shiftEn (shiftEn),
    .cmd     (cmdFields),
    .strb    (seqStrb),
    .active  (seqActive),
    .sclk    (spiClk),
    .csN     (spiCsN)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        shiftEn,
  input logic        spiClk,
  input logic        spiCsN,
  input logic        spiMosi,
  input logic        busy,
  input logic [2:0]  regAddr,
  input logic [31:0] regRdData
);
  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN); // R3

  AST_CS_HELD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !spiCsN); // R3

  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (spiClk && $past(spiClk)) |-> $stable(spiMosi)); // R4

  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !spiClk); // R4

  AST_CLK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiClk) |-> $past(shiftEn)); // R11

  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd6) |-> (regRdData == {31'b0, !busy})); // R10

  AST_EXEC_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd0) |-> (!regRdData[0] && regRdData[1] == busy)); // R2
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (.*);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        shiftEn = 1'b0;
  logic        spiClk, spiCsN, spiMosi, busy;
  logic        spiMiso = 1'b0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (.*);

  // Bus monitor and strobe generator
  int   riseCnt = 0, csFalls = 0, highChg = 0;
  logic capBits [0:1023];
  logic prevClk = 1'b0, prevCs = 1'b1, prevMosi = 1'b0;
  int   divSel = 0, divCnt = 0;
  logic strobeOff = 1'b0;

  function automatic logic patBit(int i);
    return (((i * 37) + 11) % 13) > 6;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (!prevClk && spiClk) begin
        if (riseCnt < 1024) capBits[riseCnt] = spiMosi;
        riseCnt++;
      end
      if (prevClk && spiClk && spiMosi !== prevMosi) highChg++;
      if (prevCs && !spiCsN) csFalls++;
      prevClk  = spiClk;
      prevCs   = spiCsN;
      prevMosi = spiMosi;
      spiMiso  = patBit(riseCnt);
      if (strobeOff) begin
        shiftEn = 1'b0;
      end else if (divCnt >= divSel) begin
        shiftEn = 1'b1; divCnt = 0;
      end else begin
        shiftEn = 1'b0; divCnt++;
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd7;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] s;
    int run = 0;
    int polls = 0;
    while (run < 3 && polls < 20000) begin
      regRead(3'd6, s);
      if (s[0]) run++; else run = 0;
      polls++;
    end
    check(req, "three idle polls reached", run, 3);
  endtask

  task automatic clearMon();
    riseCnt = 0; csFalls = 0; highChg = 0;
  endtask

  task automatic runVector(input logic [31:0] cmd, input logic [31:0] addr,
                           input logic [31:0] lo, input logic [31:0] hi, input int div);
    logic        eb [0:1023];
    logic [63:0] wdat, expRd;
    logic [31:0] rd;
    int n = 0, rdStart, mism = 0;
    int rdN, addrN, wrN, dum;
    rdN = int'(cmd[22:20]) + 1; addrN = int'(cmd[17:16]) + 1;
    wrN = int'(cmd[14:12]) + 1; dum = int'(cmd[11:7]);
    wdat = {hi, lo}; expRd = '0;
    for (int b = 7; b >= 0; b--) begin eb[n] = cmd[24 + b]; n++; end
    if (cmd[19])
      for (int k = 0; k < addrN; k++)
        for (int b = 7; b >= 0; b--) begin eb[n] = addr[8 * (addrN - 1 - k) + b]; n++; end
    for (int d = 0; d < dum; d++) begin eb[n] = 1'b0; n++; end
    if (cmd[15])
      for (int k = 0; k < wrN; k++)
        for (int b = 7; b >= 0; b--) begin eb[n] = wdat[8 * k + b]; n++; end
    rdStart = n;
    if (cmd[23])
      for (int k = 0; k < rdN; k++)
        for (int b = 7; b >= 0; b--) begin
          eb[n] = 1'b0;
          expRd[8 * k + b] = patBit(rdStart + 8 * k + (7 - b));
          n++;
        end
    divSel = div;
    regWrite(3'd1, addr);
    regWrite(3'd2, lo);
    regWrite(3'd3, hi);
    clearMon();
    regWrite(3'd0, cmd | 32'd1);
    waitIdle("R2");
    check("R3/R8", "serial clock count", riseCnt, n);
    for (int i = 0; i < n && i < 1024; i++) if (capBits[i] !== eb[i]) mism++;
    check("R3/R4/R5/R6/R8", "mosi bit mismatches", mism, 0);
    check("R4", "mosi changes while clock high", highChg, 0);
    check("R3", "chip select falls", csFalls, 1);
    regRead(3'd4, rd);
    check("R7", "read data low", rd, expRd[31:0]);
    regRead(3'd5, rd);
    check("R7", "read data high", rd, expRd[63:32]);
    regRead(3'd0, rd);
    check("R1", "command word readback", rd, cmd & 32'hFFFF_FFFC);
  endtask

  localparam logic [127:0] VEC [7] = '{
    {32'h0600_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h9FA0_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {32'h0BFA_0400, 32'h00AB_CDEF, 32'h0000_0000, 32'h0000_0000},
    {32'h020B_C000, 32'h1234_5678, 32'h4433_2211, 32'h8877_6655},
    {32'hD80A_0000, 32'hFF12_3456, 32'h0000_0000, 32'h0000_0000},
    {32'h5A8B_9180, 32'h89AB_CDEF, 32'hC3A5_5A3C, 32'h0000_0000},
    {32'hA5F0_FF80, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0123_4567}
  };

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    check("R12", "chip select after reset", spiCsN, 1);
    check("R12", "clock after reset", spiClk, 0);
    check("R12", "busy after reset", busy, 0);
    for (int a = 0; a < 6; a++) begin
      regRead(3'(a), rd);
      check("R12", "register after reset", rd, 0);
    end
    regRead(3'd6, rd);
    check("R12", "status after reset", rd, 1);

    for (int i = 0; i < 7; i++)
      runVector(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], i % 3);

    // R9: command word write during a running command
    divSel = 2;
    clearMon();
    regWrite(3'd0, 32'hA5F0_FF81);
    regRead(3'd0, rd);
    check("R2", "in-progress bit while running", rd[1], 1);
    check("R2", "execute bit reads zero", rd[0], 0);
    regRead(3'd6, rd);
    check("R10", "status while running", rd, 0);
    repeat (40) @(negedge clk);
    regWrite(3'd0, 32'h1100_0001);
    waitIdle("R9");
    regRead(3'd0, rd);
    check("R9", "fields kept after ignored write", rd, 32'hA5F0_FF80);
    check("R9", "chip select falls", csFalls, 1);
    repeat (30) @(negedge clk);
    check("R9", "no restart busy", busy, 0);
    check("R9", "no restart chip select", spiCsN, 1);

    // R11: no strobes, no clock movement
    divSel = 0;
    strobeOff = 1'b1;
    clearMon();
    regWrite(3'd0, 32'h0600_0001);
    repeat (30) @(negedge clk);
    check("R11", "clock edges without strobe", riseCnt, 0);
    check("R11", "clock level without strobe", spiClk, 0);
    check("R11", "chip select held low", spiCsN, 0);
    strobeOff = 1'b0;
    waitIdle("R11");
    check("R11", "clocks once strobes resume", riseCnt, 8);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule